// File: doc/BRIEF.md
# Modem Handshake Status Register

This block watches four active-low modem handshake lines (clear to send, data set ready, ring and carrier detect) and presents them to a host as one 8-bit status word. Each line crosses into the clock domain through a chain of flops. The status word carries two kinds of information. The upper four bits show the current line levels, inverted so that an asserted line reads as 1. The lower four bits are change flags. A flag sets when its line has moved and stays set until the host reads the word.

A host read is a one-cycle strobe. The word is valid during that cycle and shows the state before the clear. The flags clear at the clock edge that ends the read. An interrupt request is a level output. It is high while the interrupt enable is high and at least one change flag is set. Reading the word clears the flags, and that drops the request. Master reset clears the flags. The block does not report lines that are already asserted at reset as changes.

Top module: `modem_status_unit`

## Requirements
- R1: `stat_q[4]`, `stat_q[5]`, `stat_q[6]` and `stat_q[7]` show the inverted synchronized levels of `cts_n`, `dsr_n`, `ring_n` and `dcd_n`. Each bit follows its input SYNC_STAGES (default 2) clock edges after the input changes.
- R2: `stat_q[0]` sets only when `cts_n` goes from low to high. A high-to-low move of `cts_n` leaves the flag clear. The flag appears one edge after the level bit updates.
- R3: `stat_q[1]`, `stat_q[2]` and `stat_q[3]` set on any change of `dsr_n`, `ring_n` and `dcd_n`, in either direction. Each flag appears one edge after its level bit updates.
- R4: A change flag stays set until a host read, even when its line changes again or returns to its earlier level.
- R5: While `stat_rd` is high, `stat_q` shows the flags as they were before the read. All flags clear at the clock edge that samples `stat_rd` high.
- R6: If a new change is detected at the same edge that clears the flags for a read, that line's flag stays set.
- R7: `irq` is high exactly when `irq_en` is high and at least one change flag is set. Lowering `irq_en` masks the request but does not clear the flags.
- R8: While `rst` is high, all flags and `irq` are cleared. After reset the level bits follow the inputs, and no flag sets even when lines were asserted during reset.
- R9: Changes on several lines at the same time each set their own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous master reset, active high |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready line, active low, asynchronous |
| ring_n | input | 1 | Ring line, active low, asynchronous |
| dcd_n | input | 1 | Carrier-detect line, active low, asynchronous |
| stat_rd | input | 1 | Host read strobe for the status word; clears the flags |
| irq_en | input | 1 | Enables the modem status interrupt request |
| stat_q | output | 8 | Status word: change flags in [3:0], inverted levels in [7:4] |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a read strobe that lands on the exact edge where a new change is being flagged. That edge comes SYNC_STAGES+1 edges after the input moves. The stimulus first sets one flag, then moves a second line, and raises `stat_rd` for the single cycle that spans that edge. The expected result is that the older flag clears and the newer one survives. The other awkward case is reset with lines held asserted. The bench holds all four lines low through reset and confirms that only the level bits react.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
package msr_pkg;
   localparam int unsigned MSR_LINES = 4;

   // Line order fixes the bit position of both flag and level
   typedef enum logic [1:0] {
      LN_CTS  = 2'd0,
      LN_DSR  = 2'd1,
      LN_RING = 2'd2,
      LN_DCD  = 2'd3
   } msr_line_e;

   typedef struct packed {
      logic [MSR_LINES-1:0] level;   // [7:4]
      logic [MSR_LINES-1:0] delta;   // [3:0]
   } msr_word_t;
endpackage

// File: rtl/msr_sync.sv
`timescale 1ns/1ps
module msr_sync #(
   parameter int unsigned     WIDTH   = 4,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msr_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("msr_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < int'(STAGES); k++) chain_q[k] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
         for (int k = 1; k < int'(STAGES); k++) chain_q[k] <= chain_q[k-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/msr_edge.sv
`timescale 1ns/1ps
module msr_edge #(
   parameter int unsigned      WIDTH     = 4,
   parameter int unsigned      STAGES    = 2,
   parameter logic [WIDTH-1:0] RISE_MASK = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] hit_o
);
   // Edges only count once both the synchronizer output and the
   // history register hold post-reset samples.
   localparam int unsigned     WARM_END  = STAGES + 1;
   localparam int unsigned     CW        = $clog2(WARM_END + 1);
   localparam logic [CW-1:0]   WARM_LAST = CW'(WARM_END);
   localparam logic [CW-1:0]   WARM_ONE  = CW'(1);

   logic [CW-1:0]    warm_q;
   logic             armed;
   logic [WIDTH-1:0] prev_q;
   logic [WIDTH-1:0] raw;

   assign armed = (warm_q == WARM_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         warm_q <= '0;
         prev_q <= '1;
      end else begin
         if (!armed) warm_q <= warm_q + WARM_ONE;
         prev_q <= lvl_i;
      end
   end

   generate
      for (genvar i = 0; i < int'(WIDTH); i++) begin : g_bit
         if (RISE_MASK[i]) begin : g_rise
            assign raw[i] = ~prev_q[i] & lvl_i[i];
         end else begin : g_any
            assign raw[i] = prev_q[i] ^ lvl_i[i];
         end
      end
   endgenerate

   assign hit_o = armed ? raw : '0;
endmodule

// File: rtl/msr_flags.sv
`timescale 1ns/1ps
module msr_flags #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] hit_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] flags_o
);
   logic [WIDTH-1:0] flags_q;

   // New detections win over the read clear
   always_ff @(posedge clk) begin
      if (rst) flags_q <= '0;
      else     flags_q <= (flags_q & ~{WIDTH{clr_i}}) | hit_i;
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
module modem_status_unit
   import msr_pkg::*;
#(
   parameter int unsigned          SYNC_STAGES    = 2,
   parameter logic [MSR_LINES-1:0] RISE_ONLY_MASK = 4'b0001
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cts_n,
   input  logic       dsr_n,
   input  logic       ring_n,
   input  logic       dcd_n,
   input  logic       stat_rd,
   input  logic       irq_en,
   output logic [7:0] stat_q,
   output logic       irq
);
   localparam int unsigned WORD_W = 2 * MSR_LINES;

   generate
      if (WORD_W != 8) begin : g_bad_word
         $error("modem_status_unit: status word must be 8 bits");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("modem_status_unit: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSR_LINES-1:0] line_n;
   logic [MSR_LINES-1:0] sync_n;
   logic [MSR_LINES-1:0] edge_hit;
   logic [MSR_LINES-1:0] flags;
   msr_word_t            word;

   assign line_n[LN_CTS]  = cts_n;
   assign line_n[LN_DSR]  = dsr_n;
   assign line_n[LN_RING] = ring_n;
   assign line_n[LN_DCD]  = dcd_n;

   msr_sync #(
      .WIDTH   (MSR_LINES),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({MSR_LINES{1'b1}})
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (line_n),
      .q_o (sync_n)
   );

   msr_edge #(
      .WIDTH     (MSR_LINES),
      .STAGES    (SYNC_STAGES),
      .RISE_MASK (RISE_ONLY_MASK)
   ) u_edge (
      .clk   (clk),
      .rst   (rst),
      .lvl_i (sync_n),
      .hit_o (edge_hit)
   );

   msr_flags #(
      .WIDTH (MSR_LINES)
   ) u_flags (
      .clk     (clk),
      .rst     (rst),
      .hit_i   (edge_hit),
      .clr_i   (stat_rd),
      .flags_o (flags)
   );

   assign word.level = ~sync_n;
   assign word.delta = flags;
   assign stat_q     = word;
   assign irq        = irq_en & (|flags);
endmodule

// File: rtl/msr_chk.sv
`timescale 1ns/1ps
module msr_chk #(
   parameter logic [3:0] RISE_MASK = 4'b0001
) (
   input logic       clk,
   input logic       rst,
   input logic       stat_rd,
   input logic       irq_en,
   input logic [7:0] stat_q,
   input logic       irq,
   input logic [3:0] hit
);
   assert_reset_clear_R8: assert property (@(posedge clk)
      rst |=> (stat_q[3:0] == 4'h0 && !irq));

   assert_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

   assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
      stat_rd |=> (stat_q[3:0] == $past(hit)));

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
      (stat_rd && hit != 4'h0) |=> ((stat_q[3:0] & $past(hit)) == $past(hit)));

   assert_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
      !irq_en |-> !irq);

   assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
      irq |-> (stat_q[3:0] != 4'h0));

   generate
      for (genvar i = 0; i < 4; i++) begin : g_line
         if (RISE_MASK[i]) begin : g_rise
            assert_rise_only_R2: assert property (@(posedge clk) disable iff (rst)
               $rose(stat_q[i]) |-> ($past(stat_q[4+i], 2) && !$past(stat_q[4+i])));
         end else begin : g_any
            assert_change_cause_R3: assert property (@(posedge clk) disable iff (rst)
               $rose(stat_q[i]) |-> ($past(stat_q[4+i]) != $past(stat_q[4+i], 2)));
         end
      end
   endgenerate
endmodule

bind modem_status_unit msr_chk #(.RISE_MASK(RISE_ONLY_MASK)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .stat_rd (stat_rd),
   .irq_en  (irq_en),
   .stat_q  (stat_q),
   .irq     (irq),
   .hit     (edge_hit)
);

// File: tb/tb_modem_status_unit.sv
`timescale 1ns/1ps
module tb_modem_status_unit;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cts_n = 1'b1;
   logic       dsr_n = 1'b1;
   logic       ring_n = 1'b1;
   logic       dcd_n = 1'b1;
   logic       stat_rd = 1'b0;
   logic       irq_en = 1'b0;
   logic [7:0] stat_q;
   logic       irq;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   modem_status_unit dut (
      .clk     (clk),
      .rst     (rst),
      .cts_n   (cts_n),
      .dsr_n   (dsr_n),
      .ring_n  (ring_n),
      .dcd_n   (dcd_n),
      .stat_rd (stat_rd),
      .irq_en  (irq_en),
      .stat_q  (stat_q),
      .irq     (irq)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic host_read();
      stat_rd = 1'b1;
      step(1);
      stat_rd = 1'b0;
   endtask

   task automatic t_reset_levels();
      cts_n = 0; dsr_n = 0; ring_n = 0; dcd_n = 0;
      irq_en = 1'b1;
      rst = 1'b1;
      step(3);
      rst = 1'b0;
      step(6);
      check("R8", "levels only after reset", stat_q, 8'hF0);
      check("R8", "irq after reset", {7'd0, irq}, 8'h00);
      cts_n = 1; dsr_n = 1; ring_n = 1; dcd_n = 1;
      step(3);
      check("R9", "all four flagged", stat_q, 8'h0F);
      check("R7", "irq with flags", {7'd0, irq}, 8'h01);
      stat_rd = 1'b1;
      check("R5", "word during read", stat_q, 8'h0F);
      step(1);
      stat_rd = 1'b0;
      check("R5", "cleared after read", stat_q, 8'h00);
      check("R7", "irq drops on clear", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_cts();
      cts_n = 1'b0;
      step(2);
      check("R1", "cts level after sync", stat_q, 8'h10);
      step(3);
      check("R2", "falling cts not flagged", stat_q, 8'h10);
      cts_n = 1'b1;
      step(2);
      check("R1", "cts level released", stat_q, 8'h00);
      step(1);
      check("R2", "rising cts flagged", stat_q, 8'h01);
      check("R7", "irq on cts flag", {7'd0, irq}, 8'h01);
      host_read();
      check("R5", "cts flag cleared", stat_q, 8'h00);
   endtask

   task automatic t_any_change();
      dsr_n = 0; ring_n = 0; dcd_n = 0;
      step(3);
      check("R3", "falling edges flagged", stat_q, 8'hEE);
      host_read();
      check("R5", "levels kept, flags cleared", stat_q, 8'hE0);
      dsr_n = 1; ring_n = 1; dcd_n = 1;
      step(3);
      check("R3", "rising edges flagged", stat_q, 8'h0E);
      host_read();
   endtask

   task automatic t_sticky();
      dsr_n = 1'b0;
      step(3);
      check("R3", "dsr change flagged", stat_q, 8'h22);
      dsr_n = 1'b1;
      step(3);
      check("R4", "flag holds after return", stat_q, 8'h02);
      step(5);
      check("R4", "flag holds while idle", stat_q, 8'h02);
      host_read();
      check("R4", "flag gone after read", stat_q, 8'h00);
   endtask

   task automatic t_same_cycle();
      dsr_n = 1'b0;
      step(3);
      ring_n = 1'b0;
      step(2);
      stat_rd = 1'b1;
      check("R5", "pre-clear word", stat_q, 8'h62);
      step(1);
      stat_rd = 1'b0;
      check("R6", "new flag survives read", stat_q, 8'h64);
      dsr_n = 1'b1; ring_n = 1'b1;
      step(3);
      host_read();
      check("R6", "cleanup", stat_q, 8'h00);
   endtask

   task automatic t_mask();
      irq_en = 1'b0;
      dcd_n = 1'b0;
      step(3);
      check("R7", "flag set while masked", stat_q, 8'h88);
      check("R7", "irq masked", {7'd0, irq}, 8'h00);
      irq_en = 1'b1;
      #1;
      check("R7", "irq on enable", {7'd0, irq}, 8'h01);
      step(1);
      host_read();
      check("R7", "irq after clear", {7'd0, irq}, 8'h00);
      dcd_n = 1'b1;
      step(3);
      check("R3", "dcd release flagged", stat_q, 8'h08);
      host_read();
      check("R5", "final clear", stat_q, 8'h00);
   endtask

   initial begin
      step(2);
      t_reset_levels();
      t_cts();
      t_any_change();
      t_sticky();
      t_same_cycle();
      t_mask();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule